// File: doc/BRIEF.md
# Wide-AND Hazard Stimulus Sequencer

This block produces a parameterised-width test vector for a wide AND reduction and walks it through a fixed program, one vector per accepted step. The program has three phases. The first is a basic sweep with a single travelling zero. The second is an exhaustive pairwise sweep: a lone zero jumps straight from one bit position to another, with no intermediate vector that clears both. This is the hardest case for hazards in an AND tree. The third is a monotonic fill that raises one bit per step, as a set of completion flags would.

The vector only moves on cycles where the step-enable input is high, so a slow device under test can be paced. A start pulse launches the program from idle or from the finished state. A built-in checker registers the reduction result returned by the device under test. It compares that result with the reduction of the vector that was driven one cycle earlier, and records the first disagreement.

Top module: `wand_stimulus`

## Requirements
- R1: After synchronous reset, phase is 0 (idle), the vector is all zeros, and busy, done and the error flag are 0. The latched error vector is all zeros.
- R2: A start pulse while not busy enters phase 1 at step 0 (all zeros) on the next cycle, whatever step-enable is. A start pulse while busy changes neither phase nor vector.
- R3: While busy, the vector and phase change only on cycles where step-enable is high. Otherwise they hold.
- R4: Phase 1 presents W+4 vectors in this order: all zeros, all ones, W vectors with exactly one zero at bit 0, 1, ..., W-1 in that order, all ones, all zeros.
- R5: Phase 2 walks pairs (i, j) with i from 0 to W-2 and j from i+1 to W-1, i outer. Each pair presents the vector with only bit i cleared, then the vector with only bit j cleared. Every phase-2 vector has exactly one zero bit.
- R6: Phase 2 lasts exactly W*(W-1) steps and covers all W*(W-1)/2 unordered pairs (276 for W=24) with a direct i-to-j zero move.
- R7: Phase 3 presents W+1 vectors. It starts from all zeros, and each step sets the next higher bit, starting at bit 0, until all bits are 1. No set bit is ever cleared during the phase.
- R8: The phase output codes are 0 idle, 1 basic sweep, 2 pairwise, 3 fill and 4 finished. Busy is high exactly in phases 1 to 3.
- R9: The step after the last fill vector enters phase 4 with an all-zeros vector. Done is high for exactly that one cycle, and a start pulse in phase 4 restarts the program at phase 1, step 0.
- R10: When the reduction input sampled at a clock edge differs from the AND of the vector driven in the cycle before that edge, the error flag is high after the next edge. The error vector then holds that driven vector. A correct reduction never raises the flag.
- R11: The error flag stays high until reset. The error vector keeps the first offending vector, and later mismatches leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, ignored while busy |
| step_en | input | 1 | Advance the vector on this cycle |
| and_in | input | 1 | Reduction result returned by the device under test |
| vec | output | W | Current test vector |
| phase | output | 3 | Program phase code |
| busy | output | 1 | Program running (phases 1 to 3) |
| done | output | 1 | One-cycle pulse on entering the finished phase |
| err | output | 1 | Sticky mismatch flag |
| err_vec | output | W | First vector that produced a mismatch |

## Verification
The bench builds the block at its default width of 24. This makes the whole 605-vector program reachable in a few hundred cycles, so every vector of all three phases is compared against a model computed from the requirements. The model also tallies the 276 distinct pairwise moves. The device under test is modelled as an exact AND with a one-cycle inversion that can be injected. This reaches the checker's first-mismatch latch, its stickiness and its behaviour on a second mismatch, alongside paced stepping and start pulses issued while the program is running.

// File: rtl/wand_stim_pkg.sv
package wand_stim_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_BASIC = 3'd1,
        PH_PAIR  = 3'd2,
        PH_FILL  = 3'd3,
        PH_FIN   = 3'd4
    } phase_e;

    localparam int PHASE_W = 3;

    function automatic logic phase_running(phase_e p);
        return (p == PH_BASIC) || (p == PH_PAIR) || (p == PH_FILL);
    endfunction

endpackage

// File: rtl/wand_step_ctrl.sv
module wand_step_ctrl
    import wand_stim_pkg::*;
#(
    parameter int W  = 24,
    parameter int KW = $clog2(W + 4),
    parameter int PW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          step_en,
    output phase_e        phase,
    output logic [KW-1:0] k,
    output logic [PW-1:0] pi,
    output logic [PW-1:0] pj,
    output logic          sub,
    output logic          done
);

    localparam logic [KW-1:0] BASIC_LAST = KW'(W + 3);
    localparam logic [KW-1:0] FILL_LAST  = KW'(W);
    localparam logic [PW-1:0] PJ_LAST    = PW'(W - 1);
    localparam logic [PW-1:0] PI_LAST    = PW'(W - 2);

    phase_e        ph_n;
    logic [KW-1:0] k_n;
    logic [PW-1:0] pi_n, pj_n;
    logic          sub_n, done_n;

    always_comb begin
        ph_n   = phase;
        k_n    = k;
        pi_n   = pi;
        pj_n   = pj;
        sub_n  = sub;
        done_n = 1'b0;
        if (!phase_running(phase)) begin
            if (start) begin
                ph_n  = PH_BASIC;
                k_n   = '0;
                pi_n  = '0;
                pj_n  = '0;
                sub_n = 1'b0;
            end
        end else if (step_en) begin
            unique case (phase)
                PH_BASIC: begin
                    if (k == BASIC_LAST) begin
                        ph_n  = PH_PAIR;
                        pi_n  = '0;
                        pj_n  = PW'(1);
                        sub_n = 1'b0;
                    end else begin
                        k_n = k + KW'(1);
                    end
                end
                PH_PAIR: begin
                    if (!sub) begin
                        sub_n = 1'b1;
                    end else if (pj != PJ_LAST) begin
                        pj_n  = pj + PW'(1);
                        sub_n = 1'b0;
                    end else if (pi != PI_LAST) begin
                        pi_n  = pi + PW'(1);
                        pj_n  = pi + PW'(2);
                        sub_n = 1'b0;
                    end else begin
                        ph_n = PH_FILL;
                        k_n  = '0;
                    end
                end
                PH_FILL: begin
                    if (k == FILL_LAST) begin
                        ph_n   = PH_FIN;
                        done_n = 1'b1;
                    end else begin
                        k_n = k + KW'(1);
                    end
                end
                default: ph_n = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            k     <= '0;
            pi    <= '0;
            pj    <= '0;
            sub   <= 1'b0;
            done  <= 1'b0;
        end else begin
            phase <= ph_n;
            k     <= k_n;
            pi    <= pi_n;
            pj    <= pj_n;
            sub   <= sub_n;
            done  <= done_n;
        end
    end

    AST_PAIR_ORDERED: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PAIR) |-> (pi < pj)); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (rst)
        done |-> (phase == PH_FIN)); // R9

endmodule

// File: rtl/wand_vec_form.sv
module wand_vec_form
    import wand_stim_pkg::*;
#(
    parameter int W  = 24,
    parameter int KW = $clog2(W + 4),
    parameter int PW = $clog2(W)
) (
    input  phase_e        phase,
    input  logic [KW-1:0] k,
    input  logic [PW-1:0] pi,
    input  logic [PW-1:0] pj,
    input  logic          sub,
    output logic [W-1:0]  vec
);

    localparam logic [W-1:0]  ONES = '1;
    localparam logic [W-1:0]  LSB  = W'(1);
    localparam logic [KW-1:0] TOP1 = KW'(W + 2);
    localparam logic [KW-1:0] TOP0 = KW'(W + 3);

    logic [PW-1:0] zpos;

    always_comb begin
        zpos = sub ? pj : pi;
        vec  = '0;
        unique case (phase)
            PH_BASIC: begin
                if (k == KW'(0) || k == TOP0)
                    vec = '0;
                else if (k == KW'(1) || k == TOP1)
                    vec = ONES;
                else
                    vec = ~(LSB << (k - KW'(2)));
            end
            PH_PAIR: vec = ~(LSB << zpos);
            PH_FILL: vec = ~(ONES << k);
            default: vec = '0;
        endcase
    end

endmodule

// File: rtl/wand_chk.sv
module wand_chk #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] vec,
    input  logic         and_in,
    output logic         err,
    output logic [W-1:0] err_vec
);

    logic         and_q;
    logic [W-1:0] vec_q;
    logic         mism;

    always_ff @(posedge clk) begin
        if (rst) begin
            and_q <= 1'b0;
            vec_q <= '0;
        end else begin
            and_q <= and_in;
            vec_q <= vec;
        end
    end

    assign mism = and_q != (&vec_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            err     <= 1'b0;
            err_vec <= '0;
        end else if (mism && !err) begin
            err     <= 1'b1;
            err_vec <= vec_q;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err |=> err); // R11

    AST_ERR_VEC_HELD: assert property (@(posedge clk) disable iff (rst)
        err |=> $stable(err_vec)); // R11

endmodule

// File: rtl/wand_stimulus.sv
module wand_stimulus
    import wand_stim_pkg::*;
#(
    parameter int W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                step_en,
    input  logic                and_in,
    output logic [W-1:0]        vec,
    output logic [PHASE_W-1:0]  phase,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic [W-1:0]        err_vec
);

    localparam int KW = $clog2(W + 4);
    localparam int PW = $clog2(W);

    phase_e        ph;
    logic [KW-1:0] k;
    logic [PW-1:0] pi, pj;
    logic          sub;

    wand_step_ctrl #(.W(W), .KW(KW), .PW(PW)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .step_en(step_en),
        .phase(ph), .k(k), .pi(pi), .pj(pj), .sub(sub), .done(done)
    );

    wand_vec_form #(.W(W), .KW(KW), .PW(PW)) u_form (
        .phase(ph), .k(k), .pi(pi), .pj(pj), .sub(sub), .vec(vec)
    );

    wand_chk #(.W(W)) u_chk (
        .clk(clk), .rst(rst), .vec(vec), .and_in(and_in),
        .err(err), .err_vec(err_vec)
    );

    assign phase = ph;
    assign busy  = phase_running(ph);

    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy && !step_en) |=> ($stable(vec) && $stable(phase))); // R3

    AST_PAIR_ONE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd2) |-> ($countones(~vec) == 1)); // R5

    AST_FILL_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd3) |=> ((phase != 3'd3) || ((vec & $past(vec)) == $past(vec)))); // R7

    AST_FIN_ZERO: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd4) |-> (vec == '0)); // R9

endmodule

// File: tb/wand_stimulus_test.sv
module wand_stimulus_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int W      = 24;
    localparam int NBASIC = W + 4;
    localparam int NPAIR  = W * (W - 1);
    localparam int NFILL  = W + 1;
    localparam int NALL   = NBASIC + NPAIR + NFILL;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         step_en = 1'b0;
    logic         inj = 1'b0;
    logic         and_in;
    logic [W-1:0] vec, err_vec;
    logic [2:0]   phase;
    logic         busy, done, err;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    assign and_in = inj ? ~(&vec) : (&vec);

    wand_stimulus #(.W(W)) uut (
        .clk(clk), .rst(rst), .start(start), .step_en(step_en), .and_in(and_in),
        .vec(vec), .phase(phase), .busy(busy), .done(done), .err(err), .err_vec(err_vec)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_vec(int n);
        logic [W-1:0] ones = '1;
        if (n < NBASIC) begin
            if (n == 0 || n == NBASIC - 1) return '0;
            if (n == 1 || n == NBASIC - 2) return ones;
            return ~(W'(1) << (n - 2));
        end else if (n < NBASIC + NPAIR) begin
            int off = n - NBASIC;
            int p = off / 2;
            int cnt = 0;
            for (int i = 0; i < W - 1; i++)
                for (int j = i + 1; j < W; j++) begin
                    if (cnt == p) return ~(W'(1) << ((off % 2) ? j : i));
                    cnt++;
                end
            return '0;
        end else if (n < NALL) begin
            return ~(ones << (n - NBASIC - NPAIR));
        end
        return '0;
    endfunction

    function automatic logic [2:0] exp_phase(int n);
        if (n < NBASIC) return 3'd1;
        if (n < NBASIC + NPAIR) return 3'd2;
        if (n < NALL) return 3'd3;
        return 3'd4;
    endfunction

    function automatic string req_of(int n);
        if (n < NBASIC) return "R4";
        if (n < NBASIC + NPAIR) return "R5";
        return "R7";
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start = 1'b0; step_en = 1'b0; inj = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic test_reset();
        do_reset();
        check("R1", "phase", 32'(phase), 32'd0);
        check("R1", "vec", 32'(vec), 32'd0);
        check("R1", "busy", 32'(busy), 32'd0);
        check("R1", "done", 32'(done), 32'd0);
        check("R1", "err", 32'(err), 32'd0);
        check("R1", "err_vec", 32'(err_vec), 32'd0);
    endtask

    task automatic test_full_run();
        bit seen [W][W];
        int pairs = 0;
        int pair_steps = 0;
        logic [W-1:0] prev = '0;
        int bad = 0;
        start = 1'b1; step_en = 1'b1;
        for (int n = 0; n <= NALL + 1; n++) begin
            @(negedge clk);
            start = 1'b0;
            if (n < NALL) begin
                if (vec !== exp_vec(n) || phase !== exp_phase(n) || busy !== 1'b1 || done !== 1'b0) begin
                    bad++;
                    check(req_of(n), $sformatf("vector %0d", n), 32'(vec), 32'(exp_vec(n)));
                    check("R8", $sformatf("phase %0d", n), 32'(phase), 32'(exp_phase(n)));
                end
                if (phase == 3'd2) begin
                    pair_steps++;
                    if (((n - NBASIC) % 2) == 1) begin
                        int a = -1, b = -1;
                        for (int q = 0; q < W; q++) begin
                            if (!prev[q]) a = q;
                            if (!vec[q]) b = q;
                        end
                        if (a >= 0 && b > a && !seen[a][b]) begin
                            seen[a][b] = 1'b1;
                            pairs++;
                        end
                    end
                end
                prev = vec;
            end else if (n == NALL) begin
                check("R9", "done on finish", 32'(done), 32'd1);
                check("R8", "finished phase", 32'(phase), 32'd4);
                check("R8", "busy finished", 32'(busy), 32'd0);
                check("R9", "finished vec", 32'(vec), 32'd0);
            end else begin
                check("R9", "done one cycle", 32'(done), 32'd0);
                check("R9", "phase stays", 32'(phase), 32'd4);
            end
        end
        check("R4", "program vectors mismatched", 32'(bad), 32'd0);
        check("R6", "pair phase steps", 32'(pair_steps), 32'(NPAIR));
        check("R6", "distinct pairs", 32'(pairs), 32'(W * (W - 1) / 2));
        check("R10", "no false error", 32'(err), 32'd0);
        step_en = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9", "restart phase", 32'(phase), 32'd1);
        check("R9", "restart vec", 32'(vec), 32'd0);
    endtask

    task automatic test_pacing();
        do_reset();
        start = 1'b1; step_en = 1'b0;
        @(negedge clk);
        start = 1'b0;
        check("R2", "start enters basic", 32'(phase), 32'd1);
        check("R2", "start vec", 32'(vec), 32'd0);
        @(negedge clk);
        @(negedge clk);
        check("R3", "hold without step", 32'(vec), 32'd0);
        step_en = 1'b1;
        @(negedge clk);
        step_en = 1'b0;
        check("R3", "one step", 32'(vec), 32'(exp_vec(1)));
        step_en = 1'b1;
        @(negedge clk);
        step_en = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2", "start ignored busy vec", 32'(vec), 32'(exp_vec(2)));
        check("R2", "start ignored busy phase", 32'(phase), 32'd1);
        @(negedge clk);
        check("R3", "hold after gap", 32'(vec), 32'(exp_vec(2)));
        step_en = 1'b1;
        @(negedge clk);
        step_en = 1'b0;
        check("R4", "walking zero bit 1", 32'(vec), 32'(exp_vec(3)));
    endtask

    task automatic test_checker();
        logic [W-1:0] bad_v;
        do_reset();
        start = 1'b1; step_en = 1'b0;
        @(negedge clk);
        start = 1'b0; step_en = 1'b1;
        @(negedge clk);
        step_en = 1'b0;
        bad_v = vec;
        check("R4", "all ones step", 32'(bad_v), 32'(exp_vec(1)));
        inj = 1'b1;
        @(negedge clk);
        inj = 1'b0;
        check("R10", "err not yet", 32'(err), 32'd0);
        @(negedge clk);
        check("R10", "err raised", 32'(err), 32'd1);
        check("R10", "err vector", 32'(err_vec), 32'(bad_v));
        step_en = 1'b1;
        @(negedge clk);
        step_en = 1'b0;
        inj = 1'b1;
        @(negedge clk);
        inj = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R11", "err sticky", 32'(err), 32'd1);
        check("R11", "first vector kept", 32'(err_vec), 32'(bad_v));
        do_reset();
        check("R1", "reset clears err", 32'(err), 32'd0);
        check("R1", "reset clears err_vec", 32'(err_vec), 32'd0);
    endtask

    initial begin
        test_reset();
        test_full_run();
        test_pacing();
        test_checker();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule